// File: doc/BRIEF.md
# NAND Write-Path BCH Parity Generator

This block sits on the write path of a NAND flash controller and computes the parity of an 8-error-correcting binary BCH code as data bytes stream out to the flash. Software configures a few control levels: a length select that picks a 512-byte main-area sector or a 24-byte spare or metadata chunk, a two-bit code-type field, and a lock level. It then pulses an init strobe to clear the engine. From then on, every byte written through the byte-write strobe is folded into a 104-bit remainder. There is no further software action.

When the selected number of bytes has been absorbed, the remainder is copied into four 32-bit result words and a done flag rises. The engine then ignores further writes until the next init. This keeps the captured parity steady while software reads it, and it keeps trailing spare-area bytes out of the main sector's parity. The code works over GF(2^13), so the parity is 13 × 8 = 104 bits. The generator polynomial is a parameter. The remainder advances one full byte per clock.

Top module: `bch_wr_parity`

## Requirements
- R1: With `cfg_short_msg` = 0 the message is 512 accepted bytes, and with `cfg_short_msg` = 1 it is 24 accepted bytes. `done` stays 0 until the last byte of that count has been accepted.
- R2: Bytes are accepted only while `cfg_ecc_mode` equals binary 01. Under the values 00, 10 and 11 a written byte changes neither the parity nor the byte count.
- R3: While `cfg_lock` is 1, written bytes change neither the parity state nor the byte count.
- R4: An `cfg_init` pulse while `cfg_lock` is 0 clears the parity state, the byte count and `done`. An `cfg_init` pulse while `cfg_lock` is 1 has no effect, so software must unlock first and then init.
- R5: The captured parity equals the remainder of M(x)·x^104 divided by the generator g(x). M(x) takes the first byte as its highest-order coefficients, with each byte most-significant bit first.
- R6: Capture is automatic. The result words and `done` take their new values on the same clock edge that accepts the final message byte.
- R7: Parity bit k appears in result word k/32 at bit k mod 32. Bits 31:8 of `parity_w3` are always 0.
- R8: After capture, writes are ignored until the next accepted init. The result words hold the last captured parity until the next capture, and an init alone does not clear them.
- R9: When an accepted init and a byte write fall in the same cycle, the init wins and the byte is discarded.
- R10: After reset, all result words are 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_short_msg | input | 1 | Message length select: 0 = 512 bytes, 1 = 24 bytes |
| cfg_ecc_mode | input | 2 | Code-type field; 01 enables the 8-error BCH engine |
| cfg_lock | input | 1 | 1 freezes parity generation and blocks init |
| cfg_init | input | 1 | Init strobe; clears state when unlocked |
| wr_en | input | 1 | Byte-write strobe |
| wr_data | input | 8 | Byte being written |
| parity_w0 | output | 32 | Parity bits 31:0 |
| parity_w1 | output | 32 | Parity bits 63:32 |
| parity_w2 | output | 32 | Parity bits 95:64 |
| parity_w3 | output | 32 | Parity bits 103:96 in 7:0, zero above |
| done | output | 1 | Set on capture, cleared by init |

## Verification
Two functions can land in the same cycle: an accepted init and a byte write. The bench provokes this by asserting the init strobe and the write strobe together in the middle of a message. It then streams a further 24 bytes. The collision is judged correct only if `done` is still 0 after 23 of those bytes and rises on the 24th, and if the captured parity matches a bit-serial model of just those 24 bytes. A second coincidence is an init requested while the lock is high during a partial message. This is judged by the final parity still covering every byte written before and after it.

// File: rtl/bch_wr_pkg.sv
package bch_wr_pkg;

    localparam int unsigned GF_M      = 13;
    localparam int unsigned T_CORR    = 8;
    localparam int unsigned PAR_W     = GF_M * T_CORR;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned N_WORDS   = (PAR_W + WORD_W - 1) / WORD_W;
    localparam int unsigned PAD_W     = N_WORDS * WORD_W - PAR_W;
    localparam int unsigned LONG_LEN  = 512;
    localparam int unsigned SHORT_LEN = 24;
    localparam int unsigned CNT_W     = $clog2(LONG_LEN);

    typedef logic [PAR_W-1:0] par_t;

    // Low-order coefficients of g(x); the x^PAR_W term is implicit.
    localparam par_t GEN_DEFAULT = 104'h9C3A_5E71_B04D_F28E_6A13_C7D5_29;

    typedef enum logic [1:0] {
        ECC_OFF  = 2'b00,
        ECC_BCH8 = 2'b01,
        ECC_RSV2 = 2'b10,
        ECC_RSV3 = 2'b11
    } ecc_mode_e;

    typedef struct packed {
        logic clear;
        logic accept;
        logic last;
    } seq_ctl_t;

    function automatic logic [CNT_W-1:0] last_index(input logic short_sel);
        return short_sel ? CNT_W'(SHORT_LEN - 1) : CNT_W'(LONG_LEN - 1);
    endfunction

    // One step of polynomial division, message bit entering at the top.
    function automatic par_t fold_bit(input par_t rem, input logic din, input par_t gen);
        logic fb;
        fb = din ^ rem[PAR_W-1];
        return {rem[PAR_W-2:0], 1'b0} ^ (fb ? gen : '0);
    endfunction

endpackage

// File: rtl/bch_wr_seq.sv
module bch_wr_seq
    import bch_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       short_sel,
    input  logic [1:0] mode,
    input  logic       lock,
    input  logic       init,
    input  logic       wr_en,
    output seq_ctl_t   ctl,
    output logic       done
);

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             init_ok;
    logic             take;
    logic             at_end;

    always_comb begin
        init_ok    = init & ~lock;
        take       = wr_en & (mode == ECC_BCH8) & ~lock & ~done_q & ~init_ok;
        at_end     = (cnt_q >= last_index(short_sel));
        ctl.clear  = init_ok;
        ctl.accept = take;
        ctl.last   = take & at_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (init_ok) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (take) begin
            if (at_end) begin
                cnt_q  <= '0;
                done_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign done = done_q;

    // R3 / R4: a locked engine neither counts nor honours init.
    assert_lock_holds_count_R3: assert property (@(posedge clk) disable iff (rst)
        lock |=> ($stable(cnt_q) && $stable(done_q)));

    // R2: a code-type other than 01 leaves the count idle.
    assert_mode_idle_R2: assert property (@(posedge clk) disable iff (rst)
        ((mode != ECC_BCH8) && !init_ok) |=> ($stable(cnt_q) && $stable(done_q)));

    // R1: done rises only after a write was presented.
    assert_done_after_write_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(wr_en));

endmodule

// File: rtl/bch_lfsr8.sv
module bch_lfsr8
    import bch_wr_pkg::*;
#(
    parameter par_t GEN = GEN_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              accept,
    input  logic [BYTE_W-1:0] data,
    output par_t              state_q,
    output par_t              next_state
);

    par_t chain [0:BYTE_W];

    assign chain[0] = state_q;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_step
        assign chain[b+1] = fold_bit(chain[b], data[BYTE_W-1-b], GEN);
    end

    assign next_state = chain[BYTE_W];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state_q <= '0;
        end else if (accept) begin
            state_q <= next_state;
        end
    end

    // R4: an accepted init leaves an all-zero remainder.
    assert_init_clears_R4: assert property (@(posedge clk) disable iff (rst)
        clear |=> (state_q == '0));

endmodule

// File: rtl/bch_result_regs.sv
module bch_result_regs
    import bch_wr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      capture,
    input  par_t                      next_state,
    output logic [N_WORDS*WORD_W-1:0] words
);

    par_t cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (capture) begin
            cap_q <= next_state;
        end
    end

    if (PAD_W > 0) begin : g_pad
        assign words = {{PAD_W{1'b0}}, cap_q};
    end else begin : g_nopad
        assign words = cap_q;
    end

    // R8: results move only on a capture.
    assert_results_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(cap_q));

endmodule

// File: rtl/bch_wr_parity.sv
module bch_wr_parity
    import bch_wr_pkg::*;
#(
    parameter par_t GEN_POLY = GEN_DEFAULT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_short_msg,
    input  logic [1:0]  cfg_ecc_mode,
    input  logic        cfg_lock,
    input  logic        cfg_init,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [31:0] parity_w0,
    output logic [31:0] parity_w1,
    output logic [31:0] parity_w2,
    output logic [31:0] parity_w3,
    output logic        done
);

    seq_ctl_t                  ctl;
    par_t                      lfsr_q;
    par_t                      lfsr_next;
    logic [N_WORDS*WORD_W-1:0] words;

    bch_wr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .short_sel (cfg_short_msg),
        .mode      (cfg_ecc_mode),
        .lock      (cfg_lock),
        .init      (cfg_init),
        .wr_en     (wr_en),
        .ctl       (ctl),
        .done      (done)
    );

    bch_lfsr8 #(.GEN(GEN_POLY)) u_lfsr (
        .clk        (clk),
        .rst        (rst),
        .clear      (ctl.clear),
        .accept     (ctl.accept),
        .data       (wr_data),
        .state_q    (lfsr_q),
        .next_state (lfsr_next)
    );

    bch_result_regs u_res (
        .clk        (clk),
        .rst        (rst),
        .capture    (ctl.last),
        .next_state (lfsr_next),
        .words      (words)
    );

    assign parity_w0 = words[0*WORD_W +: WORD_W];
    assign parity_w1 = words[1*WORD_W +: WORD_W];
    assign parity_w2 = words[2*WORD_W +: WORD_W];
    assign parity_w3 = words[3*WORD_W +: WORD_W];

    // R3: lock freezes the remainder whatever is written.
    assert_lock_freeze_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_lock |=> $stable(lfsr_q));

    // R9: init beats a simultaneous write.
    assert_init_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_init && !cfg_lock && wr_en) |=> (!done && (lfsr_q == '0)));

    // R8: once done, results stay put until an accepted init.
    assert_done_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !(cfg_init && !cfg_lock)) |=>
            ($stable(parity_w0) && $stable(parity_w1) && $stable(parity_w2) && $stable(parity_w3) && done));

endmodule

// File: tb/bch_wr_parity_tb.sv
module bch_wr_parity_tb_top;

    localparam int          CLK_P  = 10;
    localparam int          WD_CYC = 150000;
    localparam logic [103:0] GEN_TB = 104'h9C3A_5E71_B04D_F28E_6A13_C7D5_29;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        short_sel = 1'b0;
    logic [1:0]  mode = 2'b01;
    logic        lock = 1'b0;
    logic        init = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [31:0] w0, w1, w2, w3;
    logic        done;

    int n_chk = 0;
    int n_err = 0;

    logic [103:0] exp_rem = '0;
    logic [103:0] exp_cap = '0;
    int           exp_cnt = 0;
    bit           exp_done = 1'b0;

    bch_wr_parity dut_i (
        .clk(clk), .rst(rst), .cfg_short_msg(short_sel), .cfg_ecc_mode(mode),
        .cfg_lock(lock), .cfg_init(init), .wr_en(wr_en), .wr_data(wr_data),
        .parity_w0(w0), .parity_w1(w1), .parity_w2(w2), .parity_w3(w3), .done(done)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Bit-serial long division of the message, first bit highest order.
    task automatic model_byte(input logic [7:0] d);
        for (int b = 7; b >= 0; b--) begin
            logic top;
            top = exp_rem[103] ^ d[b];
            exp_rem = exp_rem << 1;
            if (top) exp_rem = exp_rem ^ GEN_TB;
        end
    endtask

    // Starts and ends at a falling edge; outputs are settled on return.
    task automatic put(input logic [7:0] d, input bit we, input bit ini);
        bit init_ok, acc;
        int len;
        wr_data = d; wr_en = we; init = ini;
        len = short_sel ? 24 : 512;
        init_ok = ini && !lock;
        acc = we && (mode == 2'b01) && !lock && !exp_done && !init_ok;
        if (init_ok) begin
            exp_rem = '0; exp_cnt = 0; exp_done = 1'b0;
        end
        if (acc) begin
            model_byte(d);
            exp_cnt++;
            if (exp_cnt == len) begin
                exp_cap = exp_rem; exp_done = 1'b1; exp_cnt = 0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0; init = 1'b0;
    endtask

    task automatic check_state(input string req);
        chk(done == exp_done, req, "done", 128'(done), 128'(exp_done));
        chk(w0 == exp_cap[31:0],  req, "word0", 128'(w0), 128'(exp_cap[31:0]));
        chk(w1 == exp_cap[63:32], req, "word1", 128'(w1), 128'(exp_cap[63:32]));
        chk(w2 == exp_cap[95:64], req, "word2", 128'(w2), 128'(exp_cap[95:64]));
        chk(w3 == {24'h0, exp_cap[103:96]}, req, "word3", 128'(w3), 128'({24'h0, exp_cap[103:96]}));
    endtask

    function automatic logic [7:0] pick(input int pat, input int i);
        case (pat)
            0:       return 8'h00;
            1:       return 8'hFF;
            2:       return 8'(i);
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic run_msg(input bit shrt, input int pat);
        int len;
        short_sel = shrt; mode = 2'b01; lock = 1'b0;
        len = shrt ? 24 : 512;
        put(8'h00, 1'b0, 1'b1);
        for (int i = 0; i < len; i++) begin
            put(pick(pat, i), 1'b1, 1'b0);
            if (i == len - 2) chk(done == 1'b0, "R1", "done before last byte", 128'(done), 128'(0));
        end
        chk(done == 1'b1, "R6", "done on final byte", 128'(done), 128'(1));
        check_state("R5");
        chk(w3[31:8] == 24'h0, "R7", "word3 upper bits", 128'(w3[31:8]), 128'(0));
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_state("R10");

        // R1 / R5 / R6 / R7: long and short messages, several patterns.
        run_msg(1'b0, 3);
        run_msg(1'b0, 2);
        run_msg(1'b0, 1);
        for (int p = 0; p < 4; p++) run_msg(1'b1, p);
        run_msg(1'b1, 3);
        run_msg(1'b1, 3);

        // R8: trailing bytes after capture are ignored.
        for (int i = 0; i < 16; i++) put(8'($urandom), 1'b1, 1'b0);
        check_state("R8");
        // R4 / R8: init clears done but keeps the results.
        put(8'h00, 1'b0, 1'b1);
        check_state("R4");

        // R2: every non-enabling code-type value.
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            short_sel = 1'b1; mode = 2'b01;
            put(8'h00, 1'b0, 1'b1);
            for (int i = 0; i < 5; i++) put(8'($urandom), 1'b1, 1'b0);
            mode = 2'(m);
            for (int i = 0; i < 30; i++) put(8'($urandom), 1'b1, 1'b0);
            mode = 2'b01;
            for (int i = 0; i < 18; i++) put(8'($urandom), 1'b1, 1'b0);
            check_state("R2");
            put(8'($urandom), 1'b1, 1'b0);
            check_state("R2");
        end

        // R3 / R4: lock mid-message, with a blocked init inside it.
        short_sel = 1'b1; mode = 2'b01; lock = 1'b0;
        put(8'h00, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) put(8'($urandom), 1'b1, 1'b0);
        lock = 1'b1;
        for (int i = 0; i < 8; i++) put(8'($urandom), 1'b1, 1'b0);
        put(8'h5A, 1'b1, 1'b1);
        put(8'h00, 1'b0, 1'b1);
        lock = 1'b0;
        for (int i = 0; i < 13; i++) put(8'($urandom), 1'b1, 1'b0);
        check_state("R3");
        put(8'($urandom), 1'b1, 1'b0);
        check_state("R3");

        // R9: init and write in the same cycle.
        put(8'h00, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) put(8'($urandom), 1'b1, 1'b0);
        put(8'hC3, 1'b1, 1'b1);
        for (int i = 0; i < 23; i++) put(8'($urandom), 1'b1, 1'b0);
        check_state("R9");
        put(8'($urandom), 1'b1, 1'b0);
        check_state("R9");

        finish_up();
    end

endmodule